// File: doc/BRIEF.md
# One-Time Fuse Array Controller

This block sits between a simple byte-wide register bus and a small behavioural model of a one-time-programmable fuse array of 8 banks × 256 words. Only the low 8 bits of each word carry fuse data. Software selects a fuse through two address registers. The upper one holds the bank and the top three row bits. The lower one holds the remaining five row bits and a bit index. Software then either blows that single bit or runs an explicit sense cycle on the addressed word. Blowing a bit is accepted only while a key register holds 0xAA. Both operations hold a busy flag for a parameterised number of cycles and then report completion or an error.

Every fuse word also has a shadow copy that is reachable directly through an array window on the bus. A write to the window overrides the word's shadow. A read returns the shadow, which is the override if one has been written and the fuse value otherwise. Per-bank parameter masks protect banks against programming, override and read. A violation sets a bit in a write-one-to-clear error register and leaves the guarded state untouched.

Top module: `fuse_ctl`

## Requirements
- R1: After reset, every register (status, error, control, upper and lower address, key, sense data) reads 0x00, and every array word reads 0x00.
- R2: The target of an operation is taken from the address registers: bank = upper[5:3], row = {upper[2:0], lower[7:3]}, bit = lower[2:0]. The array window address 0x800 | bank<<8 | row reaches the same word.
- R3: Writing control bit 0 (offset 0x2) while idle, with key register (offset 0x6) = 0xAA and an unprotected bank, sets status bit 7 (busy) for exactly PROG_CYCLES cycles. It then sets the addressed fuse bit and status bit 1 (program done).
- R4: A program start while the key register is not 0xAA ends after PROG_CYCLES cycles without changing the fuse. It sets error bit 7 and leaves status bit 1 clear.
- R5: A program start, with the key present, to a bank set in WPROT_MASK ends without changing the fuse. It sets error bit 6 and leaves status bit 1 clear.
- R6: Writing any of control bits 3:1 (with bit 0 clear) while idle sets busy for SENSE_CYCLES cycles. The raw fuse byte of the addressed word, ignoring any override, then goes into the sense data register (offset 0x5), and status bit 0 (sense done) is set.
- R7: A program or sense start that arrives while busy, including on the edge where the running operation finishes, is ignored. A program start sets error bit 7; a sense-only start sets error bit 2.
- R8: A bus write to the array window stores the byte as that word's override, and later reads of the window return it. A word with no override reads its fuse value.
- R9: A write to the array window of a bank in OPROT_MASK leaves the word unchanged and sets error bit 5.
- R10: A read of the array window of a bank in RPROT_MASK returns 0x00 and sets error bit 4.
- R11: Status bits 1:0 (offset 0x0) and error bits (offset 0x1) clear where a one is written. A set and a clear of the same bit on the same edge leave it set.
- R12: Control bits 7:4 read back as written. Control bits 3:0 always read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; bit 11 selects the array window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the access |

## Verification
The hardest situations to reach are collisions on the edge where a running operation finishes. On that edge a new start must still be rejected, and a software clear of a done bit must lose to the done bit being set. The stimulus reaches that edge by counting idle cycles from the start write: it issues the colliding write exactly PROG_CYCLES or SENSE_CYCLES cycles after the start. A behavioural model in the bench tracks busy time, fuses, overrides and status. Every idle cycle reads status and compares it with the model, so any error of one cycle in the busy window is caught.

// File: rtl/fuse_ctl_pkg.sv
package fuse_ctl_pkg;

    localparam int DATA_W    = 8;
    localparam int BANK_W    = 3;
    localparam int ROW_W     = 8;
    localparam int BIT_W     = 3;
    localparam int ADDR_W    = 12;
    localparam int IDX_W     = BANK_W + ROW_W;
    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int NUM_WORDS = 1 << IDX_W;

    // register offsets inside the register window
    localparam logic [3:0] OFS_STATUS = 4'h0;
    localparam logic [3:0] OFS_ERROR  = 4'h1;
    localparam logic [3:0] OFS_CTRL   = 4'h2;
    localparam logic [3:0] OFS_UPPER  = 4'h3;
    localparam logic [3:0] OFS_LOWER  = 4'h4;
    localparam logic [3:0] OFS_SDATA  = 4'h5;
    localparam logic [3:0] OFS_KEY    = 4'h6;

    // status bit positions
    localparam int ST_BUSY  = 7;
    localparam int ST_PDONE = 1;
    localparam int ST_SDONE = 0;

    // error bit positions
    localparam int ER_PROG  = 7;
    localparam int ER_WPROT = 6;
    localparam int ER_OPROT = 5;
    localparam int ER_RPROT = 4;
    localparam int ER_SENSE = 2;

    localparam logic [DATA_W-1:0] KEY_VALUE = 8'hAA;

    typedef enum logic [1:0] {OP_IDLE, OP_PROG, OP_SENSE} op_kind_e;
    typedef enum logic [1:0] {FLT_NONE, FLT_NOKEY, FLT_WPROT} op_fault_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [BIT_W-1:0]  bitpos;
    } fuse_loc_t;

    typedef struct packed {
        logic      fire;
        op_kind_e  kind;
        op_fault_e fault;
        fuse_loc_t loc;
    } op_event_t;

    function automatic fuse_loc_t decode_loc(input logic [DATA_W-1:0] hi,
                                             input logic [DATA_W-1:0] lo);
        fuse_loc_t l;
        l.bank   = hi[5:3];
        l.row    = {hi[2:0], lo[7:3]};
        l.bitpos = lo[2:0];
        return l;
    endfunction

    function automatic logic [IDX_W-1:0] loc_word(input fuse_loc_t l);
        return {l.bank, l.row};
    endfunction

endpackage

// File: rtl/fuse_seq.sv
module fuse_seq
    import fuse_ctl_pkg::*;
#(
    parameter int                    PROG_CYCLES  = 8,
    parameter int                    SENSE_CYCLES = 4,
    parameter logic [NUM_BANKS-1:0]  WPROT_MASK   = '0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      req_prog,
    input  logic      req_sense,
    input  logic      key_ok,
    input  fuse_loc_t req_loc,
    output logic      busy,
    output op_event_t evt
);

    localparam int MAX_CYC = (PROG_CYCLES > SENSE_CYCLES) ? PROG_CYCLES : SENSE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    op_kind_e         kind_q;
    op_fault_e        fault_q;
    fuse_loc_t        loc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            kind_q  <= OP_IDLE;
            fault_q <= FLT_NONE;
            loc_q   <= '0;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
                kind_q <= OP_IDLE;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (req_prog) begin
            busy_q <= 1'b1;
            kind_q <= OP_PROG;
            cnt_q  <= CNT_W'(PROG_CYCLES - 1);
            loc_q  <= req_loc;
            if (!key_ok)
                fault_q <= FLT_NOKEY;
            else if (WPROT_MASK[req_loc.bank])
                fault_q <= FLT_WPROT;
            else
                fault_q <= FLT_NONE;
        end else if (req_sense) begin
            busy_q  <= 1'b1;
            kind_q  <= OP_SENSE;
            cnt_q   <= CNT_W'(SENSE_CYCLES - 1);
            loc_q   <= req_loc;
            fault_q <= FLT_NONE;
        end
    end

    always_comb begin
        evt.fire  = busy_q && (cnt_q == '0);
        evt.kind  = kind_q;
        evt.fault = fault_q;
        evt.loc   = loc_q;
    end

    assign busy = busy_q;

endmodule

// File: rtl/fuse_store.sv
module fuse_store
    import fuse_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    // shadow read port (bus window)
    input  logic [IDX_W-1:0]  rd_word,
    output logic [DATA_W-1:0] rd_data,
    // override write port
    input  logic              ovr_we,
    input  logic [IDX_W-1:0]  ovr_word,
    input  logic [DATA_W-1:0] ovr_data,
    // sequencer port: raw fuse view and bit blow
    input  logic [IDX_W-1:0]  op_word,
    output logic [DATA_W-1:0] op_fuse,
    input  logic              blow_en,
    input  logic [BIT_W-1:0]  blow_bit
);

    logic [DATA_W-1:0]    fuse_mem [NUM_WORDS];
    logic [DATA_W-1:0]    ovr_mem  [NUM_WORDS];
    logic [NUM_WORDS-1:0] fuse_used;
    logic [NUM_WORDS-1:0] ovr_used;

    logic [DATA_W-1:0] rd_fuse;
    logic [DATA_W-1:0] blow_val;

    always_comb begin
        rd_fuse  = fuse_used[rd_word] ? fuse_mem[rd_word] : '0;
        rd_data  = ovr_used[rd_word]  ? ovr_mem[rd_word]  : rd_fuse;
        op_fuse  = fuse_used[op_word] ? fuse_mem[op_word] : '0;
        blow_val = op_fuse | (DATA_W'(1) << blow_bit);
    end

    // validity flags give the blank array a defined value after reset
    always_ff @(posedge clk) begin
        if (rst) begin
            fuse_used <= '0;
            ovr_used  <= '0;
        end else begin
            if (blow_en)
                fuse_used[op_word] <= 1'b1;
            if (ovr_we)
                ovr_used[ovr_word] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (blow_en)
            fuse_mem[op_word] <= blow_val;
        if (ovr_we)
            ovr_mem[ovr_word] <= ovr_data;
    end

endmodule

// File: rtl/fuse_ctl.sv
module fuse_ctl
    import fuse_ctl_pkg::*;
#(
    parameter int                   PROG_CYCLES  = 8,
    parameter int                   SENSE_CYCLES = 4,
    parameter logic [NUM_BANKS-1:0] WPROT_MASK   = 8'h80,
    parameter logic [NUM_BANKS-1:0] OPROT_MASK   = 8'h40,
    parameter logic [NUM_BANKS-1:0] RPROT_MASK   = 8'h20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    // ---------------- address decode ----------------
    logic              is_arr;
    logic              is_reg;
    logic [BANK_W-1:0] arr_bank;
    logic [IDX_W-1:0]  arr_word;
    logic [3:0]        reg_off;

    assign is_arr   = bus_addr[ADDR_W-1];
    assign is_reg   = !is_arr && (bus_addr[ADDR_W-2:4] == '0);
    assign arr_bank = bus_addr[IDX_W-1:ROW_W];
    assign arr_word = bus_addr[IDX_W-1:0];
    assign reg_off  = bus_addr[3:0];

    logic reg_wr;
    logic arr_wr;
    logic arr_rd;
    assign reg_wr = bus_en && bus_we && is_reg;
    assign arr_wr = bus_en && bus_we && is_arr;
    assign arr_rd = bus_en && !bus_we && is_arr;

    // ---------------- register state ----------------
    logic [1:0]        done_q;
    logic [DATA_W-1:0] err_q;
    logic [3:0]        ctl_q;
    logic [DATA_W-1:0] upper_q;
    logic [DATA_W-1:0] lower_q;
    logic [DATA_W-1:0] key_q;
    logic [DATA_W-1:0] sdat_q;

    // ---------------- sequencer ----------------
    logic      ctl_wr;
    logic      req_prog;
    logic      req_sense;
    logic      seq_busy;
    op_event_t evt;
    fuse_loc_t req_loc;

    assign ctl_wr    = reg_wr && (reg_off == OFS_CTRL);
    assign req_prog  = ctl_wr && bus_wdata[0];
    assign req_sense = ctl_wr && !bus_wdata[0] && (bus_wdata[3:1] != '0);
    assign req_loc   = decode_loc(upper_q, lower_q);

    fuse_seq #(
        .PROG_CYCLES  (PROG_CYCLES),
        .SENSE_CYCLES (SENSE_CYCLES),
        .WPROT_MASK   (WPROT_MASK)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_prog  (req_prog),
        .req_sense (req_sense),
        .key_ok    (key_q == KEY_VALUE),
        .req_loc   (req_loc),
        .busy      (seq_busy),
        .evt       (evt)
    );

    // ---------------- storage ----------------
    logic              blow_en;
    logic              ovr_we;
    logic              ovr_block;
    logic              rd_block;
    logic [DATA_W-1:0] shadow_rd;
    logic [DATA_W-1:0] op_fuse;

    assign blow_en   = evt.fire && (evt.kind == OP_PROG) && (evt.fault == FLT_NONE);
    assign ovr_block = OPROT_MASK[arr_bank];
    assign rd_block  = RPROT_MASK[arr_bank];
    assign ovr_we    = arr_wr && !ovr_block;

    fuse_store u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_word  (arr_word),
        .rd_data  (shadow_rd),
        .ovr_we   (ovr_we),
        .ovr_word (arr_word),
        .ovr_data (bus_wdata),
        .op_word  (loc_word(evt.loc)),
        .op_fuse  (op_fuse),
        .blow_en  (blow_en),
        .blow_bit (evt.loc.bitpos)
    );

    // ---------------- status / error update ----------------
    logic [1:0]        done_set, done_clr;
    logic [DATA_W-1:0] err_set, err_clr;

    always_comb begin
        done_set = '0;
        err_set  = '0;
        done_clr = (reg_wr && reg_off == OFS_STATUS) ? bus_wdata[1:0] : '0;
        err_clr  = (reg_wr && reg_off == OFS_ERROR)  ? bus_wdata      : '0;

        if (evt.fire) begin
            if (evt.kind == OP_SENSE)
                done_set[ST_SDONE] = 1'b1;
            else if (evt.fault == FLT_NOKEY)
                err_set[ER_PROG] = 1'b1;
            else if (evt.fault == FLT_WPROT)
                err_set[ER_WPROT] = 1'b1;
            else
                done_set[ST_PDONE] = 1'b1;
        end
        if (req_prog && seq_busy)
            err_set[ER_PROG] = 1'b1;
        if (req_sense && seq_busy)
            err_set[ER_SENSE] = 1'b1;
        if (arr_wr && ovr_block)
            err_set[ER_OPROT] = 1'b1;
        if (arr_rd && rd_block)
            err_set[ER_RPROT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= '0;
            err_q   <= '0;
            ctl_q   <= '0;
            upper_q <= '0;
            lower_q <= '0;
            key_q   <= '0;
            sdat_q  <= '0;
        end else begin
            done_q <= (done_q & ~done_clr) | done_set;
            err_q  <= (err_q & ~err_clr) | err_set;
            if (ctl_wr)
                ctl_q <= bus_wdata[7:4];
            if (reg_wr && reg_off == OFS_UPPER)
                upper_q <= bus_wdata;
            if (reg_wr && reg_off == OFS_LOWER)
                lower_q <= bus_wdata;
            if (reg_wr && reg_off == OFS_KEY)
                key_q <= bus_wdata;
            if (evt.fire && evt.kind == OP_SENSE)
                sdat_q <= op_fuse;
        end
    end

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        if (is_arr) begin
            bus_rdata = rd_block ? '0 : shadow_rd;
        end else if (is_reg) begin
            unique case (reg_off)
                OFS_STATUS: bus_rdata = {seq_busy, 5'b0, done_q};
                OFS_ERROR:  bus_rdata = err_q;
                OFS_CTRL:   bus_rdata = {ctl_q, 4'b0};
                OFS_UPPER:  bus_rdata = upper_q;
                OFS_LOWER:  bus_rdata = lower_q;
                OFS_SDATA:  bus_rdata = sdat_q;
                OFS_KEY:    bus_rdata = key_q;
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/fuse_ctl_chk.sv
module fuse_ctl_chk
    import fuse_ctl_pkg::*;
#(
    parameter int                   PROG_CYCLES  = 8,
    parameter int                   SENSE_CYCLES = 4,
    parameter logic [NUM_BANKS-1:0] OPROT_MASK   = 8'h40,
    parameter logic [NUM_BANKS-1:0] RPROT_MASK   = 8'h20
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              busy,
    input logic [1:0]        done_q,
    input logic [DATA_W-1:0] err_q
);

    localparam int MAX_CYC = (PROG_CYCLES > SENSE_CYCLES) ? PROG_CYCLES : SENSE_CYCLES;

    int unsigned run_q;
    always_ff @(posedge clk) begin
        if (rst || !busy)
            run_q <= 0;
        else
            run_q <= run_q + 1;
    end

    logic arr_hit;
    logic ctl_hit;
    assign arr_hit = bus_en && bus_addr[ADDR_W-1];
    assign ctl_hit = bus_en && bus_we && (bus_addr == ADDR_W'(OFS_CTRL));

    // R3
    busy_window_chk: assert property (@(posedge clk) disable iff (rst)
        run_q <= MAX_CYC);

    // R3
    prog_done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q[ST_PDONE]) |-> $past(busy));

    // R6
    sense_done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q[ST_SDONE]) |-> $past(busy));

    // R7
    busy_restart_err_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_hit && bus_wdata[0] && busy) |=> err_q[ER_PROG]);

    // R9
    ovr_protect_err_chk: assert property (@(posedge clk) disable iff (rst)
        (arr_hit && bus_we && OPROT_MASK[bus_addr[IDX_W-1:ROW_W]]) |=> err_q[ER_OPROT]);

    // R10
    rd_protect_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (arr_hit && !bus_we && RPROT_MASK[bus_addr[IDX_W-1:ROW_W]]) |-> bus_rdata == '0);

    // R10
    rd_protect_err_chk: assert property (@(posedge clk) disable iff (rst)
        (arr_hit && !bus_we && RPROT_MASK[bus_addr[IDX_W-1:ROW_W]]) |=> err_q[ER_RPROT]);

endmodule

bind fuse_ctl fuse_ctl_chk #(
    .PROG_CYCLES  (PROG_CYCLES),
    .SENSE_CYCLES (SENSE_CYCLES),
    .OPROT_MASK   (OPROT_MASK),
    .RPROT_MASK   (RPROT_MASK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (seq_busy),
    .done_q    (done_q),
    .err_q     (err_q)
);

// File: tb/fuse_ctl_test.sv
`timescale 1ns/100ps
module fuse_ctl_test;

    localparam int PROG_CYC  = 8;
    localparam int SENSE_CYC = 4;
    localparam logic [7:0] WP = 8'h80;
    localparam logic [7:0] OP = 8'h40;
    localparam logic [7:0] RP = 8'h20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;

    always #2.5 clk = ~clk;

    fuse_ctl #(
        .PROG_CYCLES  (PROG_CYC),
        .SENSE_CYCLES (SENSE_CYC),
        .WPROT_MASK   (WP),
        .OPROT_MASK   (OP),
        .RPROT_MASK   (RP)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // ---------------- behavioural reference ----------------
    int m_fuse [2048];
    int m_ovr  [2048];
    bit m_ovr_v[2048];
    int m_stat, m_err, m_ctl, m_up, m_lo, m_key, m_sdat;
    int m_left, m_kind, m_fault, m_idx, m_bit;
    int set_st, set_er, clr_st, clr_er;
    bit busy_now;

    function automatic int mread(input logic [11:0] a);
        int b, w;
        if (a[11]) begin
            b = int'(a[10:8]);
            w = int'(a[10:0]);
            if (RP[b]) return 0;
            return m_ovr_v[w] ? m_ovr[w] : m_fuse[w];
        end
        if (a[10:4] != 0) return 0;
        case (a[3:0])
            4'h0: return ((m_left > 0) ? 128 : 0) | m_stat;
            4'h1: return m_err;
            4'h2: return m_ctl;
            4'h3: return m_up;
            4'h4: return m_lo;
            4'h5: return m_sdat;
            4'h6: return m_key;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 2048; i++) begin
                m_fuse[i] = 0; m_ovr[i] = 0; m_ovr_v[i] = 0;
            end
            m_stat = 0; m_err = 0; m_ctl = 0; m_up = 0; m_lo = 0;
            m_key = 0; m_sdat = 0; m_left = 0; m_kind = 0; m_fault = 0;
            m_idx = 0; m_bit = 0;
        end else begin
            busy_now = (m_left > 0);
            set_st = 0; set_er = 0; clr_st = 0; clr_er = 0;
            if (bus_en) begin
                if (bus_addr[11]) begin
                    if (bus_we) begin
                        if (OP[bus_addr[10:8]]) set_er |= 8'h20;
                        else begin
                            m_ovr[bus_addr[10:0]] = int'(bus_wdata);
                            m_ovr_v[bus_addr[10:0]] = 1;
                        end
                    end else if (RP[bus_addr[10:8]]) set_er |= 8'h10;
                end else if (bus_we && bus_addr[10:4] == 0) begin
                    case (bus_addr[3:0])
                        4'h0: clr_st = int'(bus_wdata) & 3;
                        4'h1: clr_er = int'(bus_wdata);
                        4'h2: begin
                            m_ctl = int'(bus_wdata) & 8'hF0;
                            if (bus_wdata[0]) begin
                                if (busy_now) set_er |= 8'h80;
                                else begin
                                    m_left = PROG_CYC; m_kind = 1;
                                    m_idx = ((m_up >> 3) & 7) * 256 + (m_up & 7) * 32 + (m_lo >> 3);
                                    m_bit = m_lo & 7;
                                    m_fault = (m_key != 8'hAA) ? 1 : (WP[(m_up >> 3) & 7] ? 2 : 0);
                                end
                            end else if (bus_wdata[3:1] != 0) begin
                                if (busy_now) set_er |= 8'h04;
                                else begin
                                    m_left = SENSE_CYC; m_kind = 2;
                                    m_idx = ((m_up >> 3) & 7) * 256 + (m_up & 7) * 32 + (m_lo >> 3);
                                end
                            end
                        end
                        4'h3: m_up = int'(bus_wdata);
                        4'h4: m_lo = int'(bus_wdata);
                        4'h6: m_key = int'(bus_wdata);
                        default: ;
                    endcase
                end
            end
            if (busy_now) begin
                m_left--;
                if (m_left == 0) begin
                    if (m_kind == 2) begin
                        m_sdat = m_fuse[m_idx]; set_st |= 1;
                    end else if (m_fault == 1) set_er |= 8'h80;
                    else if (m_fault == 2) set_er |= 8'h40;
                    else begin
                        m_fuse[m_idx] |= (1 << m_bit); set_st |= 2;
                    end
                end
            end
            m_stat = (m_stat & ~clr_st) | set_st;
            m_err  = (m_err & ~clr_er) | set_er;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic bus_read(input logic [11:0] a, input string tag, output int v);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = a; bus_wdata = 0;
        #1;
        v = int'(bus_rdata);
        check(tag, v, mread(a));
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        int v;
        bus_read(a, tag, v);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) rd(12'h000, tag);
    endtask

    task automatic set_loc(input int bank, input int row, input int bitn);
        bus_write(12'h003, 8'((bank << 3) | (row >> 5)));
        bus_write(12'h004, 8'(((row & 31) << 3) | bitn));
    endtask

    function automatic logic [11:0] arr(input int bank, input int row);
        return 12'(12'h800 | (bank << 8) | row);
    endfunction

    task automatic program_bit(input int bank, input int row, input int bitn, input string tag);
        set_loc(bank, row, bitn);
        bus_write(12'h006, 8'hAA);
        bus_write(12'h002, 8'h01);
        idle(PROG_CYC + 1, tag);
        bus_write(12'h006, 8'h00);
        bus_write(12'h000, 8'h03);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R3 watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int v;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        for (int o = 0; o < 7; o++) begin
            bus_read(12'(o), "R1 reset reg", v);
            check("R1 reset literal", v, 0);
        end
        bus_read(arr(3, 77), "R1 blank word", v);
        check("R1 blank literal", v, 0);

        // R12 control readback
        bus_write(12'h002, 8'hB0);
        bus_read(12'h002, "R12 ctrl readback", v);
        check("R12 ctrl literal", v, 8'hB0);

        // R3 program one bit, R2 address split
        set_loc(2, 8'hA5, 5);
        bus_write(12'h006, 8'hAA);
        bus_write(12'h002, 8'h01);
        bus_read(12'h000, "R3 busy", v);
        check("R3 busy literal", v, 8'h80);
        idle(PROG_CYC, "R3 busy window");
        bus_read(12'h000, "R3 done", v);
        check("R3 done literal", v, 8'h02);
        bus_write(12'h006, 8'h00);
        bus_read(arr(2, 8'hA5), "R2 programmed word", v);
        check("R2 word literal", v, 8'h20);
        bus_read(arr(2, 8'hA4), "R2 neighbour untouched", v);
        program_bit(2, 8'hA5, 0, "R3 second bit");
        bus_read(arr(2, 8'hA5), "R2 two bits", v);
        check("R2 two bits literal", v, 8'h21);
        program_bit(7 - 1 - 1, 8'h1F, 7, "R2 high row");
        rd(arr(5, 8'h1F), "R10 protected read");
        bus_write(12'h001, 8'hFF);

        // R6 sense via each start bit
        for (int s = 1; s <= 3; s++) begin
            set_loc(2, 8'hA5, 0);
            bus_write(12'h002, 8'(1 << s));
            idle(SENSE_CYC + 1, "R6 sense window");
            bus_read(12'h005, "R6 sense data", v);
            check("R6 sense literal", v, 8'h21);
            bus_write(12'h000, 8'h01);
        end

        // R4 no key
        set_loc(1, 10, 3);
        bus_write(12'h002, 8'h01);
        idle(PROG_CYC + 1, "R4 no key");
        bus_read(12'h001, "R4 err", v);
        check("R4 err literal", v, 8'h80);
        rd(arr(1, 10), "R4 fuse unchanged");
        bus_write(12'h001, 8'h80);

        // R5 write-protected bank
        set_loc(7, 3, 1);
        bus_write(12'h006, 8'hAA);
        bus_write(12'h002, 8'h01);
        idle(PROG_CYC + 1, "R5 wprot");
        bus_write(12'h006, 8'h00);
        bus_read(12'h001, "R5 err", v);
        check("R5 err literal", v, 8'h40);
        rd(arr(7, 3), "R5 fuse unchanged");
        bus_write(12'h001, 8'h40);

        // R7 starts while busy, including on the finishing edge
        set_loc(0, 1, 1);
        bus_write(12'h006, 8'hAA);
        bus_write(12'h002, 8'h01);
        bus_write(12'h002, 8'h04);
        bus_write(12'h002, 8'h01);
        idle(PROG_CYC - 3, "R7 busy");
        bus_write(12'h002, 8'h08);
        idle(2, "R7 after");
        bus_read(12'h001, "R7 err", v);
        check("R7 err literal", v, 8'h84);
        bus_write(12'h006, 8'h00);
        bus_write(12'h001, 8'hFF);
        bus_write(12'h000, 8'h03);

        // R11 set wins over clear on the same edge
        set_loc(0, 1, 0);
        bus_write(12'h002, 8'h02);
        idle(SENSE_CYC - 1, "R11 sense busy");
        bus_write(12'h000, 8'h01);
        bus_read(12'h000, "R11 set wins", v);
        check("R11 set wins literal", v, 8'h01);
        bus_write(12'h000, 8'h01);
        rd(12'h000, "R11 cleared");

        // R8 override and shadow read, R6 sense ignores override
        bus_write(arr(2, 8'hA5), 8'h5A);
        bus_read(arr(2, 8'hA5), "R8 override read", v);
        check("R8 override literal", v, 8'h5A);
        set_loc(2, 8'hA5, 0);
        bus_write(12'h002, 8'h08);
        idle(SENSE_CYC + 1, "R6 sense raw");
        bus_read(12'h005, "R6 raw fuse", v);
        check("R6 raw literal", v, 8'h21);
        bus_write(12'h000, 8'h01);

        // R9 override protect, R10 read protect
        bus_write(arr(6, 9), 8'h33);
        bus_read(arr(6, 9), "R9 unchanged", v);
        check("R9 unchanged literal", v, 0);
        bus_write(arr(5, 9), 8'h44);
        bus_read(arr(5, 9), "R10 zero", v);
        check("R10 zero literal", v, 0);
        bus_read(12'h001, "R9 R10 errors", v);
        check("R9 R10 err literal", v, 8'h30);

        // R11 write back what was read
        bus_write(12'h001, 8'(v));
        bus_read(12'h001, "R11 w1c", v);
        check("R11 w1c literal", v, 0);

        @(negedge clk);
        bus_en = 0;
        repeat (2) @(negedge clk);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule